// File: doc/BRIEF.md
# LCD Line-Load Timing Generator

This block produces the per-line strobes that a display panel driver needs, all counted in cycles of one reference pixel clock. Every frame is a sequence of lines: a number of dummy lines for the vertical front porch, then the lines that carry picture data, then a number of dummy lines for the vertical back porch. A one-clock horizontal sync marks the start of every line, dummy or not. A vertical sync covers the whole first line of the frame. A separate line-load strobe, which tells the panel driver to take in a line of data, is raised only on the lines that carry picture data.

The load strobe sits at a programmable offset into the line. That offset always has one clock of built-in latency, so a setting of zero still places the strobe one clock after the sync. A phase setting chooses where the data word is launched. It can go out in the same clock as the load strobe or one clock after it. The word comes from an upstream source over a valid/ready stream. The block raises `pix_ready` for the single clock in which it wants a word, and consumes the word on that clock edge only if `pix_valid` is also high. The source cannot stall the block. A word that is not offered in that clock is not waited for: that load slot passes with the data-enable low and the bus at zero.

All configuration inputs are sampled at the start of a frame, so a change made during a frame takes effect from the next frame.

Top module: `lcd_line_timer`

## Requirements
- R1: Lines are `line_period` clocks long, and a horizontal sync is seen once every `line_period` clocks.
- R2: `hsync` is high for exactly one clock, the first clock of each line. This holds on every line of the frame, including the front and back porch lines. A frame has `porch_front + active_lines + porch_back` lines.
- R3: `vsync` is high for every clock of line 0 of each frame, and low on all other lines.
- R4: `line_load` is high for one clock on each of lines `porch_front` through `porch_front + active_lines - 1`, and never on porch lines. It rises D+1 clocks after the clock in which `hsync` was high, where D is the effective delay.
- R5: The effective delay D equals `load_delay`, clamped to at most `line_period - 2`.
- R6: With `data_phase` = 0, `data_en` and the word on `data_out` appear in the same clock as `line_load`. With `data_phase` = 1 they appear one clock later, which may fall in the next line or the next frame. `data_out` is zero whenever `data_en` is low.
- R7: `pix_ready` is high in exactly the clock before each launch clock that R6 defines. A word is taken only when `pix_valid` and `pix_ready` are both high. If `pix_valid` is low in that clock, the launch slot is skipped with `data_en` low.
- R8: Period, line counts, delay and phase are sampled when a frame begins. Changing these inputs during a frame does not alter that frame.
- R9: While `rst` is high, all outputs and `pix_ready` are low and the configuration is loaded from the inputs. The first clock after `rst` falls shows line 0 with `hsync` and `vsync` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_period | input | PER_W | Clocks per line (3 or more) |
| porch_front | input | LINE_W | Dummy lines before the data lines |
| active_lines | input | LINE_W | Lines carrying data (1 or more) |
| porch_back | input | LINE_W | Dummy lines after the data lines |
| load_delay | input | PER_W | Load strobe delay in clocks, clamped |
| data_phase | input | 1 | 0: data with strobe; 1: data one clock after |
| pix_valid | input | 1 | Upstream word is offered |
| pix_ready | output | 1 | Block takes a word on this edge |
| pix_data | input | DATA_W | Upstream data word |
| vsync | output | 1 | Vertical sync, whole first line of frame |
| hsync | output | 1 | Horizontal sync, first clock of every line |
| line_load | output | 1 | Load strobe on data lines only |
| data_en | output | 1 | Data bus carries a valid word |
| data_out | output | DATA_W | Data bus toward the panel driver |

## Verification
The assertions assume that the sampled line period is at least 3 and that each frame has at least one data line. These bounds keep the one-clock sync, the clamped strobe and the launch slot inside each line. The stimulus draws periods from 3 to 12, porch counts from 0 to 3, data lines from 1 to 4 and delays from 0 to 15, so the assumptions are always met. The random delays often exceed the clamp, which exercises R5. The bench loads the next frame's configuration halfway through every frame, and it drives `pix_valid` at random with roughly one clock in four idle.

// File: rtl/lcdt_pkg.sv
`timescale 1ns/1ps
package lcdt_pkg;
  parameter int PER_W  = 8;
  parameter int LINE_W = 6;
  parameter int TOT_W  = LINE_W + 2;

  typedef struct packed {
    logic [PER_W-1:0]  per;
    logic [LINE_W-1:0] fp;
    logic [LINE_W-1:0] act;
    logic [LINE_W-1:0] bp;
    logic [PER_W-1:0]  dly;
    logic              ph;
  } lcdt_cfg_t;
endpackage

// File: rtl/lcdt_cfg_latch.sv
`timescale 1ns/1ps
module lcdt_cfg_latch
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  lcdt_cfg_t        cfg_i,
  output lcdt_cfg_t        cfg_o,
  output logic [PER_W-1:0] dly_eff_o,
  output logic [TOT_W-1:0] tot_o
);
  logic [PER_W-1:0] per_m2;

  // configuration is frozen between frame boundaries (R8)
  always_ff @(posedge clk) begin
    if (rst || take) cfg_o <= cfg_i;
  end

  always_comb begin
    per_m2    = cfg_o.per - PER_W'(2);
    dly_eff_o = (cfg_o.dly > per_m2) ? per_m2 : cfg_o.dly;   // R5 clamp
    tot_o     = TOT_W'(cfg_o.fp) + TOT_W'(cfg_o.act) + TOT_W'(cfg_o.bp);
  end

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !$past(take) && !$past(rst) |-> $stable(cfg_o));
endmodule

// File: rtl/lcdt_counter.sv
`timescale 1ns/1ps
module lcdt_counter
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PER_W-1:0] per,
  input  logic [TOT_W-1:0] tot,
  output logic [PER_W-1:0] cnt,
  output logic [TOT_W-1:0] ln,
  output logic             wrap
);
  logic eol;

  always_comb begin
    eol  = (cnt == per - PER_W'(1));
    wrap = eol && (ln == tot - TOT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ln  <= '0;
    end else if (eol) begin
      cnt <= '0;
      ln  <= wrap ? '0 : ln + TOT_W'(1);
    end else begin
      cnt <= cnt + PER_W'(1);
    end
  end

  a_r1_cnt_below_period: assert property (@(posedge clk) disable iff (rst)
    cnt < per);
  a_r2_line_in_frame: assert property (@(posedge clk) disable iff (rst)
    ln < tot);
endmodule

// File: rtl/lcdt_strobe.sv
`timescale 1ns/1ps
module lcdt_strobe
  import lcdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  lcdt_cfg_t        cfg,
  input  logic [PER_W-1:0] dly_eff,
  input  logic [PER_W-1:0] cnt,
  input  logic [TOT_W-1:0] ln,
  output logic             hs_o,
  output logic             vs_o,
  output logic             ld_o,
  output logic             ld_ph_o,
  output logic             ld_next_o
);
  logic data_line;

  always_comb begin
    data_line = (ln >= TOT_W'(cfg.fp)) &&
                (ln < TOT_W'(cfg.fp) + TOT_W'(cfg.act));
    ld_next_o = data_line && (cnt == dly_eff + PER_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o    <= 1'b0;
      vs_o    <= 1'b0;
      ld_o    <= 1'b0;
      ld_ph_o <= 1'b0;
    end else begin
      hs_o    <= (cnt == '0);
      vs_o    <= (ln == '0);
      ld_o    <= ld_next_o;
      ld_ph_o <= cfg.ph;
    end
  end

  a_r2_hs_single: assert property (@(posedge clk) disable iff (rst)
    hs_o |=> !hs_o);
  a_r4_ld_off_line_start: assert property (@(posedge clk) disable iff (rst)
    ld_o |-> !hs_o);
  a_r3_vs_starts_with_hs: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_o) |-> hs_o);
endmodule

// File: rtl/lcdt_launch.sv
`timescale 1ns/1ps
module lcdt_launch #(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_q,
  input  logic              ld_ph,
  input  logic              ld_next,
  input  logic              ph_cur,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              de_o,
  output logic [DATA_W-1:0] data_o
);
  logic launch;

  // phase 1 follows the registered strobe with its own phase; phase 0 the next one
  always_comb begin
    launch    = (ld_q && ld_ph) || (ld_next && !ph_cur);
    pix_ready = launch && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_o   <= 1'b0;
      data_o <= '0;
    end else begin
      de_o   <= pix_ready && pix_valid;
      data_o <= (pix_ready && pix_valid) ? pix_data : '0;
    end
  end

  a_r7_take_on_handshake: assert property (@(posedge clk) disable iff (rst)
    de_o |-> $past(pix_valid && pix_ready));
  a_r6_de_near_load: assert property (@(posedge clk) disable iff (rst)
    de_o |-> (ld_q || $past(ld_q)));
  a_r6_bus_quiet: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (data_o == '0));
endmodule

// File: rtl/lcd_line_timer.sv
`timescale 1ns/1ps
module lcd_line_timer
  import lcdt_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  line_period,
  input  logic [LINE_W-1:0] porch_front,
  input  logic [LINE_W-1:0] active_lines,
  input  logic [LINE_W-1:0] porch_back,
  input  logic [PER_W-1:0]  load_delay,
  input  logic              data_phase,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  output logic              vsync,
  output logic              hsync,
  output logic              line_load,
  output logic              data_en,
  output logic [DATA_W-1:0] data_out
);
  lcdt_cfg_t        cfg_in, cfg;
  logic [PER_W-1:0] dly_eff, cnt;
  logic [TOT_W-1:0] tot, ln;
  logic             wrap, ld_ph, ld_next;

  always_comb begin
    cfg_in.per = line_period;
    cfg_in.fp  = porch_front;
    cfg_in.act = active_lines;
    cfg_in.bp  = porch_back;
    cfg_in.dly = load_delay;
    cfg_in.ph  = data_phase;
  end

  lcdt_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .take(wrap), .cfg_i(cfg_in),
    .cfg_o(cfg), .dly_eff_o(dly_eff), .tot_o(tot)
  );

  lcdt_counter u_cnt (
    .clk(clk), .rst(rst), .per(cfg.per), .tot(tot),
    .cnt(cnt), .ln(ln), .wrap(wrap)
  );

  lcdt_strobe u_stb (
    .clk(clk), .rst(rst), .cfg(cfg), .dly_eff(dly_eff), .cnt(cnt), .ln(ln),
    .hs_o(hsync), .vs_o(vsync), .ld_o(line_load), .ld_ph_o(ld_ph),
    .ld_next_o(ld_next)
  );

  lcdt_launch #(.DATA_W(DATA_W)) u_lau (
    .clk(clk), .rst(rst), .ld_q(line_load), .ld_ph(ld_ph), .ld_next(ld_next),
    .ph_cur(cfg.ph), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .de_o(data_en), .data_o(data_out)
  );
endmodule

// File: tb/lcd_line_timer_test.sv
`timescale 1ns/1ps
module lcd_line_timer_test;
  import lcdt_pkg::*;
  localparam int DATA_W = 24;
  localparam int NF     = 120;

  logic clk = 1'b0, rst = 1'b1;
  logic [PER_W-1:0]  line_period, load_delay;
  logic [LINE_W-1:0] porch_front, active_lines, porch_back;
  logic              data_phase, pix_valid, pix_ready;
  logic [DATA_W-1:0] pix_data, data_out;
  logic              vsync, hsync, line_load, data_en;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lcd_line_timer #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .line_period(line_period), .porch_front(porch_front),
    .active_lines(active_lines), .porch_back(porch_back), .load_delay(load_delay),
    .data_phase(data_phase), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .vsync(vsync), .hsync(hsync), .line_load(line_load),
    .data_en(data_en), .data_out(data_out)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic apply_cfg(input lcdt_cfg_t c);
    line_period  = c.per;
    porch_front  = c.fp;
    active_lines = c.act;
    porch_back   = c.bp;
    load_delay   = c.dly;
    data_phase   = c.ph;
  endtask

  function automatic int eff_dly(input lcdt_cfg_t c);
    int m = int'(c.per) - 2;
    return (int'(c.dly) > m) ? m : int'(c.dly);
  endfunction

  function automatic bit ld_at(input lcdt_cfg_t c, input int l, input int pos);
    return (l >= int'(c.fp)) && (l < int'(c.fp) + int'(c.act)) && (pos == eff_dly(c) + 1);
  endfunction

  function automatic lcdt_cfg_t pick_cfg(input int idx);
    lcdt_cfg_t c;
    case (idx)
      0: begin c.per = 3; c.fp = 1; c.act = 2; c.bp = 1; c.dly = 0;   c.ph = 1'b0; end
      1: begin c.per = 6; c.fp = 0; c.act = 3; c.bp = 0; c.dly = 200; c.ph = 1'b1; end
      2: begin c.per = 5; c.fp = 2; c.act = 1; c.bp = 2; c.dly = 3;   c.ph = 1'b0; end
      3: begin c.per = 8; c.fp = 0; c.act = 1; c.bp = 3; c.dly = 2;   c.ph = 1'b1; end
      default: begin
        c.per = PER_W'(3 + $urandom_range(9));
        c.fp  = LINE_W'($urandom_range(3));
        c.act = LINE_W'(1 + $urandom_range(3));
        c.bp  = LINE_W'($urandom_range(3));
        c.dly = PER_W'($urandom_range(15));
        c.ph  = 1'($urandom_range(1));
      end
    endcase
    return c;
  endfunction

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    lcdt_cfg_t cur, nxt;
    bit ld_prev, ph_prev, prev_valid;
    logic [DATA_W-1:0] prev_data;
    void'($urandom(32'd20240611));
    cur = pick_cfg(0);
    apply_cfg(cur);
    pix_valid = 1'b0;
    pix_data  = '0;
    repeat (4) @(negedge clk);
    chk("R9 reset hsync", 32'(hsync), 0);
    chk("R9 reset vsync", 32'(vsync), 0);
    chk("R9 reset load", 32'(line_load), 0);
    chk("R9 reset de", 32'(data_en), 0);
    chk("R9 reset ready", 32'(pix_ready), 0);
    chk("R9 reset data", 32'(data_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 first clock hsync", 32'(hsync), 1);
    chk("R9 first clock vsync", 32'(vsync), 1);
    ld_prev = 0; ph_prev = 0; prev_valid = 0; prev_data = '0;
    for (int f = 0; f < NF; f++) begin
      int tot, mid, k;
      nxt = pick_cfg(f + 1);
      tot = int'(cur.fp) + int'(cur.act) + int'(cur.bp);
      mid = (tot * int'(cur.per)) / 2;
      k = 0;
      for (int l = 0; l < tot; l++) begin
        for (int pos = 0; pos < int'(cur.per); pos++) begin
          bit ld_e, slot, de_e, ldn, rdy_e;
          ld_e  = ld_at(cur, l, pos);
          slot  = (ld_e && !cur.ph) || (ld_prev && ph_prev);
          de_e  = slot && prev_valid;
          ldn   = (pos + 1 < int'(cur.per)) ? ld_at(cur, l, pos + 1) : 1'b0;
          rdy_e = (ld_e && cur.ph) || (ldn && !cur.ph);
          chk("R1/R2 hsync", 32'(hsync), 32'(pos == 0));
          chk("R3 vsync", 32'(vsync), 32'(l == 0));
          chk("R4 R5 R8 line_load", 32'(line_load), 32'(ld_e));
          chk("R6 data_en", 32'(data_en), 32'(de_e));
          chk("R6 data_out", 32'(data_out), de_e ? 32'(prev_data) : 32'd0);
          chk("R7 pix_ready", 32'(pix_ready), 32'(rdy_e));
          ld_prev = ld_e;
          ph_prev = cur.ph;
          if (k == mid) apply_cfg(nxt);   // R8: takes effect next frame
          prev_valid = ($urandom_range(3) != 0);
          prev_data  = DATA_W'($urandom);
          pix_valid  = prev_valid;
          pix_data   = prev_data;
          k++;
          @(negedge clk);
        end
      end
      cur = nxt;
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule